// File: doc/BRIEF.md
# Horizontal motion clock stuffer

This block applies fine horizontal motion to a set of movable screen objects (five by default). Each object holds a small motion value. A motion strobe starts a shared down counter, and the counter is compared against every stored value. Until an object's comparator fires, that object receives one extra clock-enable pulse on each phase-1 pulse of the two-phase line clock. Each extra pulse advances the object's position counter by a quarter count, so the object moves one pixel to the left. The position counters are outside this block; it only produces the stuffed enables.

A stored value is written from the upper nibble of the data bus. Its most significant bit is inverted on the way in, so a signed move of +7..-8 becomes a left-move count of 15..0. The comparator does not test for binary equality. It stops an object when every stored bit differs from the matching counter bit. Because of this, an object whose value is rewritten in the middle of a sequence to a pattern that shares a bit with every remaining counter state, and with the idle value, never stops. It keeps receiving a pulse on every phase-1 until the next motion strobe. A clear strobe resets every stored value to the zero-motion encoding but does not cancel pending motion.

A late-blank flag is raised on the motion strobe. The line timing logic reads it to end blanking later, and it is dropped when that logic signals a line wrap.

Top module: `hmc_stuffer`

## Requirements
- R1: A write stores `{~d[3], d[2:0]}` of the 4-bit motion nibble d. A motion sequence then delivers to that object exactly as many stuffed pulses as the stored value (0..15).
- R2: Stuffed pulses appear only in cycles where phase-1 is high, and at most one per object per phase-1 pulse.
- R3: The sequence starts at the first phase-2 pulse after the strobe cycle. The counter runs 15 down to 0, one step per phase-2, and returns to idle 15 after 16 compares. All pulses of a normal sequence arrive within 72 clocks of the strobe.
- R4: An object's pending-motion latch clears at a phase-1 compare when every stored bit differs from the counter bit, and the pulse of that cycle is suppressed. The counter is compared on every phase-1, including when idle at 15.
- R5: A stored value rewritten mid-sequence so that it never becomes the bitwise complement of the counter leaves the object receiving one pulse on every phase-1 (one per 4 clocks). This continues until a later strobe re-arms it with a value that clears.
- R6: The clear strobe sets every stored value to 1000 (an 8-pulse sequence). It does not clear pending-motion latches.
- R7: A per-object write in the same cycle as the clear strobe wins for that object.
- R8: The late-blank flag is high from the cycle after a motion strobe. It goes low the cycle after a line-wrap pulse. A strobe in the same cycle as a wrap keeps the flag high.
- R9: After reset no stuffed pulses appear, the flag is low and every stored value is 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ph1_i | input | 1 | Phase-1 pulse, one clock in four |
| ph2_i | input | 1 | Phase-2 pulse, two clocks after phase-1 |
| move_i | input | 1 | Motion strobe |
| clr_i | input | 1 | Clear-all-motion strobe |
| wr_en_i | input | NUM_OBJ | Per-object motion write enable |
| wr_motion_i | input | CNT_W | Upper nibble of the written motion value |
| line_wrap_i | input | 1 | Line wrap pulse from the sync counter; drops the flag |
| stuff_o | output | NUM_OBJ | Stuffed clock enable per object |
| hm_late_o | output | 1 | Late-blank (motion pending) flag |

## Verification
The checks assume that phase-1 and phase-2 are single-cycle pulses that are never high together and are two clocks apart. They also assume that a strobe never lands in the cycle where a re-arm coincides with phase-1. The bench produces both phases from one free-running divide-by-four generator, so the clock inputs always keep that shape. It drives the strobes and writes on falling edges, so they fall into arbitrary phase slots and still keep within these rules. Random motion values and clear strobes vary the counts, while directed cases cover each value 0..15, the write-versus-clear collision and the mid-sequence rewrite.

// File: rtl/hmc_pkg.sv
package hmc_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_RUN  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/hmc_seq.sv
// Shared motion sequencer: waits for phase-2, then steps the compare
// counter from all-ones down to zero, one step per phase-2 pulse.
module hmc_seq
   import hmc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ph2_i,
   input  logic             go_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             arm_o
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign cnt_o = cnt_q;
   assign arm_o = ph2_i && (state_q == SEQ_WAIT) && !go_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         cnt_q   <= CNT_TOP;
      end else if (go_i) begin
         state_q <= SEQ_WAIT;
      end else if (ph2_i) begin
         unique case (state_q)
            SEQ_WAIT: begin
               state_q <= SEQ_RUN;
               cnt_q   <= CNT_TOP;
            end
            SEQ_RUN: begin
               if (cnt_q == '0) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= CNT_TOP;
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hmc_slot.sv
// One object's motion store, pending-motion latch and mismatch comparator.
module hmc_slot #(
   parameter int CNT_W   = 4,
   parameter bit INV_MSB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ph1_i,
   input  logic             arm_i,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] nib_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             stuff_o
);
   localparam logic [CNT_W-1:0] MSB_MASK = {1'b1, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W-1:0] CLR_VAL  = INV_MSB ? MSB_MASK : '0;

   logic [CNT_W-1:0] enc;
   logic [CNT_W-1:0] val_q;
   logic             more_q;
   logic             hit;

   generate
      if (INV_MSB) begin : g_inv
         assign enc = nib_i ^ MSB_MASK;
      end else begin : g_plain
         assign enc = nib_i;
      end
   endgenerate

   // stop when no stored bit agrees with the counter bit
   assign hit     = &(val_q ^ cnt_i);
   assign stuff_o = ph1_i && more_q && !hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= CLR_VAL;
      end else if (wr_i) begin
         val_q <= enc;
      end else if (clr_i) begin
         val_q <= CLR_VAL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         more_q <= 1'b0;
      end else if (arm_i) begin
         more_q <= 1'b1;
      end else if (ph1_i && hit) begin
         more_q <= 1'b0;
      end
   end
endmodule

// File: rtl/hmc_late_flag.sv
// Late-blank flag: set by the motion strobe, dropped on line wrap.
module hmc_late_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wrap_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (wrap_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/hmc_stuffer.sv
module hmc_stuffer #(
   parameter int NUM_OBJ = 5,
   parameter int CNT_W   = 4,
   parameter bit INV_MSB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ph1_i,
   input  logic               ph2_i,
   input  logic               move_i,
   input  logic               clr_i,
   input  logic [NUM_OBJ-1:0] wr_en_i,
   input  logic [CNT_W-1:0]   wr_motion_i,
   input  logic               line_wrap_i,
   output logic [NUM_OBJ-1:0] stuff_o,
   output logic               hm_late_o
);
   generate
      if (NUM_OBJ < 1) begin : g_bad_obj
         $error("hmc_stuffer: NUM_OBJ must be at least 1");
      end
      if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt
         $error("hmc_stuffer: CNT_W must lie in 2..8");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             arm;

   hmc_seq #(.CNT_W(CNT_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .ph2_i (ph2_i),
      .go_i  (move_i),
      .cnt_o (cnt),
      .arm_o (arm)
   );

   for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
      hmc_slot #(.CNT_W(CNT_W), .INV_MSB(INV_MSB)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .ph1_i   (ph1_i),
         .arm_i   (arm),
         .clr_i   (clr_i),
         .wr_i    (wr_en_i[g]),
         .nib_i   (wr_motion_i),
         .cnt_i   (cnt),
         .stuff_o (stuff_o[g])
      );
   end

   hmc_late_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (move_i),
      .wrap_i (line_wrap_i),
      .flag_o (hm_late_o)
   );
endmodule

// File: rtl/hmc_stuffer_chk.sv
module hmc_stuffer_chk #(
   parameter int NUM_OBJ = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ph1_i,
   input logic               ph2_i,
   input logic               move_i,
   input logic               line_wrap_i,
   input logic [NUM_OBJ-1:0] stuff_o,
   input logic               hm_late_o
);
   logic seen_move_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      seen_move_q <= 1'b0;
      else if (move_i) seen_move_q <= 1'b1;
   end

   p_phase_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(ph1_i && ph2_i));

   p_stuff_on_ph1_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|stuff_o) |-> ph1_i);

   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|stuff_o) |=> (stuff_o == '0));

   p_quiet_until_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_move_q |-> (stuff_o == '0));

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      move_i |=> hm_late_o);

   p_flag_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_wrap_i && !move_i) |=> !hm_late_o);
endmodule

bind hmc_stuffer hmc_stuffer_chk #(.NUM_OBJ(NUM_OBJ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ph1_i       (ph1_i),
   .ph2_i       (ph2_i),
   .move_i      (move_i),
   .line_wrap_i (line_wrap_i),
   .stuff_o     (stuff_o),
   .hm_late_o   (hm_late_o)
);

// File: tb/hmc_stuffer_bench.sv
module hmc_stuffer_bench;
   localparam int NO = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    ph_cnt = 2'd0;
   logic          ph1, ph2;
   logic          move = 1'b0, clr = 1'b0, wrap = 1'b0;
   logic [NO-1:0] wr_en = '0;
   logic [3:0]    wr_nib = 4'h0;
   logic [NO-1:0] stuff;
   logic          late;

   int tot [NO];
   int bad_phase = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) ph_cnt <= 2'd0;
      else        ph_cnt <= ph_cnt + 2'd1;
   end
   assign ph1 = rst_n && (ph_cnt == 2'd0);
   assign ph2 = rst_n && (ph_cnt == 2'd2);

   hmc_stuffer u_hmc_stuffer (
      .clk(clk), .rst_n(rst_n), .ph1_i(ph1), .ph2_i(ph2),
      .move_i(move), .clr_i(clr), .wr_en_i(wr_en), .wr_motion_i(wr_nib),
      .line_wrap_i(wrap), .stuff_o(stuff), .hm_late_o(late)
   );

   initial begin
      for (int i = 0; i < NO; i++) tot[i] = 0;
      forever begin
         @(negedge clk);
         #5;
         for (int i = 0; i < NO; i++) tot[i] += int'(stuff[i]);
         if (stuff != '0 && !ph1) bad_phase++;
      end
   end

   function automatic int exp_count(input logic [3:0] nib);
      return int'({~nib[3], nib[2:0]});
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int idx, input logic [3:0] nib, input bit with_clr);
      @(negedge clk);
      wr_en = '0;
      wr_en[idx] = 1'b1;
      wr_nib = nib;
      clr = with_clr;
      @(negedge clk);
      wr_en = '0;
      clr = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); move = 1'b1;
      @(negedge clk); move = 1'b0;
   endtask

   // run a sequence and compare per-object pulse totals
   task automatic run_seq(input string req, input int exp [NO]);
      int s0 [NO];
      int s1 [NO];
      for (int i = 0; i < NO; i++) s0[i] = tot[i];
      strobe();
      tick(71);
      for (int i = 0; i < NO; i++) s1[i] = tot[i];
      tick(30);
      for (int i = 0; i < NO; i++) begin
         check(s1[i] - s0[i] == exp[i], req, s1[i] - s0[i], exp[i]);
         check(tot[i] == s1[i], "R3 late pulses", tot[i] - s1[i], 0);
      end
   endtask

   initial begin
      int exp [NO];
      int s0;
      int unsigned sd;
      sd = $urandom(32'd4242);
      tick(3);
      #5;
      check(stuff == '0, "R9 stuff in reset", int'(stuff), 0);
      @(negedge clk); rst_n = 1'b1;
      tick(2); #5;
      check(stuff == '0, "R9 stuff after reset", int'(stuff), 0);
      check(late == 1'b0, "R9 flag after reset", int'(late), 0);

      // R9: reset value 1000 -> 8 pulses each; R8 flag from strobe
      for (int i = 0; i < NO; i++) exp[i] = 8;
      run_seq("R9 reset motion", exp);
      #5;
      check(late == 1'b1, "R8 flag after strobe", int'(late), 1);
      @(negedge clk); wrap = 1'b1;
      @(negedge clk); wrap = 1'b0; #5;
      check(late == 1'b0, "R8 flag after wrap", int'(late), 0);
      @(negedge clk); wrap = 1'b1; move = 1'b1;
      @(negedge clk); wrap = 1'b0; move = 1'b0; #5;
      check(late == 1'b1, "R8 strobe beats wrap", int'(late), 1);
      tick(80);

      // R1 R4: every value 0..15 on every object
      for (int v = 0; v < 16; v++) begin
         for (int k = 0; k < NO; k++) begin
            logic [3:0] st;
            st = 4'((v + k) % 16);
            wr(k, st ^ 4'b1000, 1'b0);
            exp[k] = exp_count(st ^ 4'b1000);
         end
         run_seq("R1 R4 directed count", exp);
      end

      // R6 clear strobe, R7 write beats clear
      for (int k = 0; k < NO; k++) wr(k, 4'h5, 1'b0);
      pulse_clr();
      for (int i = 0; i < NO; i++) exp[i] = 8;
      run_seq("R6 clear value", exp);
      wr(2, 4'h3, 1'b1);
      exp[2] = 11;
      run_seq("R7 write over clear", exp);

      // random values, occasional clear
      for (int it = 0; it < 20; it++) begin
         for (int k = 0; k < NO; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            wr(k, r, 1'b0);
            exp[k] = exp_count(r);
         end
         if (($urandom % 4) == 0) begin
            pulse_clr();
            for (int k = 0; k < NO; k++) exp[k] = 8;
         end
         run_seq("R1 random count", exp);
      end

      // R5 perpetual stuffing after a mid-sequence rewrite
      wr(0, 4'h7, 1'b0);
      for (int k = 1; k < NO; k++) wr(k, 4'h8, 1'b0);
      s0 = tot[0];
      strobe();
      while (tot[0] - s0 < 15) begin
         @(negedge clk); #6;
      end
      wr(0, 4'h6, 1'b0);
      tick(100);
      s0 = tot[0];
      tick(400);
      check(tot[0] - s0 == 100, "R5 perpetual pulses", tot[0] - s0, 100);
      pulse_clr();
      s0 = tot[0];
      tick(400);
      check(tot[0] - s0 == 100, "R6 clear keeps latch", tot[0] - s0, 100);
      wr(0, 4'h8, 1'b0);
      strobe();
      tick(100);
      s0 = tot[0];
      tick(400);
      check(tot[0] - s0 == 0, "R5 stopped by strobe", tot[0] - s0, 0);

      check(bad_phase == 0, "R2 pulse off phase-1", bad_phase, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule